// File: doc/BRIEF.md
# Fixed-Point LMS Weight Trainer

This block trains the weight vector of a single-layer functional-link network. An upstream expander supplies the expanded terms of one input sample as a stream, one term per cycle. The block multiplies each term by its stored weight and adds the products to form the network output. It subtracts that output from the desired value to get the error. It then makes a second pass over the same terms, which it has buffered internally, and moves every weight by the learning rate times the error times that weight's own term.

All arithmetic is signed Q4.12: 16 bits with 12 fraction bits, so 1.0 is 4096. Every product, sum and weight saturates instead of wrapping. The squared error of each iteration is added to an epoch accumulator. At the last iteration of an epoch, the accumulated sum is compared against a programmable mean-squared-error threshold and a sticky converged flag may be set. Once that flag is set, the block accepts no further training data until a restart pulse returns every weight to 1.0.

Top module: `lms_trainer`

## Requirements
- R1: After reset or a restart pulse, every weight reads 4096 (1.0), `conv_o` is 0 and `ready_o` is 1.
- R2: While `ready_o` is high, a term is accepted on every cycle that `term_valid_i` is high. The first accepted term of an iteration also captures `desired_i` and `mu_i`. After NW terms (NW = ORDER+2, six by default), `done_o` pulses for one cycle. During that pulse, `y_o`, `err_o`, the weights and `conv_o` already reflect the iteration.
- R3: `y_o` is the sum over k of m(term_k, w_k), saturated to 16 bits. Here m(a,b) is (a*b) arithmetically shifted right by 12, then saturated to the range -32768..32767.
- R4: `err_o` equals desired minus `y_o`, saturated to 16 bits.
- R5: Each weight w_k becomes sat(w_k + m(m(mu, err), term_k)), where sat is a saturating 16-bit add.
- R6: Results that overflow clip to 32767 or -32768 at every stage (product, output, error, weight). They never wrap.
- R7: `mu_i` is taken as unsigned Q4.12 in the range [0, 1.0]. Any value above 4096 acts as exactly 4096, and a value of 0 leaves every weight unchanged.
- R8: Each iteration adds (err*err)>>12 to an epoch sum. At the iteration that completes `epoch_len_i` iterations (an `epoch_len_i` of 0 counts as 1), `conv_o` is set if and only if that sum is strictly less than `thresh_i` times the epoch length. The sum and the count then clear. `conv_o` never rises at any other iteration.
- R9: While `conv_o` is 1, it stays 1, `ready_o` is 0, presented terms are ignored, no `done_o` pulse occurs and the weights do not change.
- R10: A restart pulse clears `conv_o` and any partial epoch sum, and returns all weights to 4096.
- R11: `rd_weight_o` shows the weight selected by `rd_idx_i` in the same cycle, and shows 0 for an index of NW or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Reinitialise weights and clear convergence |
| term_valid_i | input | 1 | Expanded term present on term_i |
| term_i | input | 16 | Expanded term, signed Q4.12 |
| desired_i | input | 16 | Desired output, signed Q4.12, taken with the first term |
| mu_i | input | 16 | Learning rate, unsigned Q4.12, taken with the first term |
| thresh_i | input | 16 | Mean-squared-error threshold, unsigned Q4.12 |
| epoch_len_i | input | 8 | Iterations per epoch |
| ready_o | output | 1 | Terms can be accepted |
| done_o | output | 1 | One-cycle pulse at the end of an iteration |
| y_o | output | 16 | Network output of the last iteration |
| err_o | output | 16 | Error of the last iteration |
| conv_o | output | 1 | Sticky converged flag |
| rd_idx_i | input | 3 | Weight read index |
| rd_weight_o | output | 16 | Selected weight |

## Verification
The main training path is driven with four term vectors of mixed sign and magnitude, each with a different learning rate. Because the vectors run back to back without a restart, an error in the weight carry-over, the term buffering or the update order shows up as wrong outputs in the following iterations. Vectors at full scale separate saturating arithmetic from wrapping arithmetic, and an oversized learning rate is compared against a rate of exactly 1.0. Epoch tests place the squared-error sum exactly at the threshold and one LSB below it, close an epoch on its second iteration, and use a zero epoch length. Together these separate a strict comparison from a non-strict one and show whether the flag is evaluated only at epoch boundaries.

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int unsigned DW   = 16;
  localparam int unsigned FRAC = 12;

  typedef logic signed [DW-1:0] fx_t;
  typedef enum logic [1:0] {ST_COLLECT, ST_ERR, ST_UPD, ST_FIN} state_e;

  localparam fx_t FX_ONE = fx_t'(1 << FRAC);
  localparam fx_t FX_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam fx_t FX_MIN = {1'b1, {(DW-1){1'b0}}};

  // (a*b)>>>FRAC clipped to DW bits
  function automatic fx_t sat_mul(input fx_t a, input fx_t b);
    logic signed [2*DW-1:0] p;
    p = (2*DW)'(a) * (2*DW)'(b);
    p = p >>> FRAC;
    if ((&p[2*DW-1:DW-1]) || !(|p[2*DW-1:DW-1])) return p[DW-1:0];
    return p[2*DW-1] ? FX_MIN : FX_MAX;
  endfunction

  function automatic fx_t sat_add(input fx_t a, input fx_t b);
    logic signed [DW:0] s;
    s = {a[DW-1], a} + {b[DW-1], b};
    if (s[DW] == s[DW-1]) return s[DW-1:0];
    return s[DW] ? FX_MIN : FX_MAX;
  endfunction
endpackage

// File: rtl/lms_term_buf.sv
module lms_term_buf #(
  parameter int unsigned NW = 6,
  parameter int unsigned DW = 16,
  localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [NW];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NW; k++) begin
      if (rd_idx_i == IW'(k)) rd_data_o = mem_q[k];
    end
  end
endmodule

// File: rtl/lms_weight_bank.sv
module lms_weight_bank
  import lms_pkg::*;
#(
  parameter int unsigned NW = 6,
  localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             upd_en_i,
  input  logic [IW-1:0]    upd_idx_i,
  input  fx_t              upd_val_i,
  input  logic [IW-1:0]    rd_a_idx_i,
  output fx_t              rd_a_o,
  input  logic [IW-1:0]    rd_b_idx_i,
  output fx_t              rd_b_o,
  output logic [NW*DW-1:0] w_flat_o
);
  for (genvar g = 0; g < NW; g++) begin : g_w
    fx_t w_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  w_r <= FX_ONE;
      else if (restart_i)                           w_r <= FX_ONE;
      else if (upd_en_i && upd_idx_i == IW'(g))     w_r <= upd_val_i;
    end
    assign w_flat_o[g*DW +: DW] = w_r;

    AST_RESTART_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> (w_r == FX_ONE)); // R1
  end

  always_comb begin
    rd_a_o = '0;
    rd_b_o = '0;
    for (int k = 0; k < NW; k++) begin
      if (rd_a_idx_i == IW'(k)) rd_a_o = w_flat_o[k*DW +: DW];
      if (rd_b_idx_i == IW'(k)) rd_b_o = w_flat_o[k*DW +: DW];
    end
  end
endmodule

// File: rtl/lms_mse_mon.sv
module lms_mse_mon #(
  parameter int unsigned SQ_W = 20,
  parameter int unsigned EPW  = 8,
  parameter int unsigned DW   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            sample_i,
  input  logic [SQ_W-1:0] sq_i,
  input  logic [DW-1:0]   thresh_i,
  input  logic [EPW-1:0]  epoch_len_i,
  output logic            conv_o
);
  localparam int unsigned ACC_W = SQ_W + EPW + DW;

  logic [ACC_W-1:0] sum_q, sum_nx, limit;
  logic [EPW-1:0]   cnt_q, len_eff;
  logic             boundary, conv_q;

  assign len_eff  = (epoch_len_i == '0) ? EPW'(1) : epoch_len_i;
  assign boundary = ({1'b0, cnt_q} + (EPW+1)'(1)) >= {1'b0, len_eff};
  assign sum_nx   = sum_q + ACC_W'(sq_i);
  assign limit    = ACC_W'(thresh_i) * ACC_W'(len_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      conv_q <= 1'b0;
    end else if (restart_i) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      conv_q <= 1'b0;
    end else if (sample_i) begin
      if (boundary) begin
        if (sum_nx < limit) conv_q <= 1'b1;
        sum_q <= '0;
        cnt_q <= '0;
      end else begin
        sum_q <= sum_nx;
        cnt_q <= cnt_q + EPW'(1);
      end
    end
  end

  assign conv_o = conv_q;

  AST_CONV_AT_EPOCH_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> $past(sample_i && boundary)); // R8
  AST_CONV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_o && !restart_i) |=> conv_o); // R9
endmodule

// File: rtl/lms_trainer.sv
module lms_trainer
  import lms_pkg::*;
#(
  parameter int unsigned ORDER = 4,
  parameter int unsigned EPW   = 8,
  localparam int unsigned NW   = ORDER + 2,
  localparam int unsigned IW   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            term_valid_i,
  input  logic [DW-1:0]   term_i,
  input  logic [DW-1:0]   desired_i,
  input  logic [DW-1:0]   mu_i,
  input  logic [DW-1:0]   thresh_i,
  input  logic [EPW-1:0]  epoch_len_i,
  output logic            ready_o,
  output logic            done_o,
  output logic [DW-1:0]   y_o,
  output logic [DW-1:0]   err_o,
  output logic            conv_o,
  input  logic [IW-1:0]   rd_idx_i,
  output logic [DW-1:0]   rd_weight_o
);
  localparam int unsigned AW   = DW + IW + 1;
  localparam int unsigned SQ_W = 2*DW - FRAC;
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  state_e          state_q;
  logic [IW-1:0]   idx_q;
  logic signed [AW-1:0] acc_q, prod_ext;
  fx_t             desired_q, mu_q, y_q, err_q;
  fx_t             w_cur, buf_term, prod, y_sat, err_sat, mu_eff, gain, delta, w_new;
  logic signed [DW:0] diff;
  logic signed [2*DW-1:0] esq;
  logic [SQ_W-1:0] sq;
  logic            term_fire, conv;
  logic [NW*DW-1:0] w_flat;

  assign ready_o   = (state_q == ST_COLLECT) && !conv;
  assign term_fire = ready_o && term_valid_i;

  lms_term_buf #(.NW(NW), .DW(DW)) i_buf (
    .clk_i     (clk_i),
    .wr_en_i   (term_fire),
    .wr_idx_i  (idx_q),
    .wr_data_i (term_i),
    .rd_idx_i  (idx_q),
    .rd_data_o (buf_term)
  );

  lms_weight_bank #(.NW(NW)) i_wbank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart_i),
    .upd_en_i   (state_q == ST_UPD),
    .upd_idx_i  (idx_q),
    .upd_val_i  (w_new),
    .rd_a_idx_i (idx_q),
    .rd_a_o     (w_cur),
    .rd_b_idx_i (rd_idx_i),
    .rd_b_o     (rd_weight_o),
    .w_flat_o   (w_flat)
  );

  // forward pass
  assign prod     = sat_mul(term_i, w_cur);
  assign prod_ext = {{(AW-DW){prod[DW-1]}}, prod};

  always_comb begin
    if ((&acc_q[AW-1:DW-1]) || !(|acc_q[AW-1:DW-1])) y_sat = acc_q[DW-1:0];
    else y_sat = acc_q[AW-1] ? FX_MIN : FX_MAX;
    diff = {desired_q[DW-1], desired_q} - {y_sat[DW-1], y_sat};
    if (diff[DW] == diff[DW-1]) err_sat = diff[DW-1:0];
    else err_sat = diff[DW] ? FX_MIN : FX_MAX;
  end

  // update pass
  assign mu_eff = ($unsigned(mu_q) > $unsigned(FX_ONE)) ? FX_ONE : mu_q;
  assign gain   = sat_mul(mu_eff, err_q);
  assign delta  = sat_mul(gain, buf_term);
  assign w_new  = sat_add(w_cur, delta);

  assign esq = (2*DW)'(err_sat) * (2*DW)'(err_sat);
  assign sq  = esq[2*DW-1:FRAC];

  lms_mse_mon #(.SQ_W(SQ_W), .EPW(EPW), .DW(DW)) i_mse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_i),
    .sample_i    (state_q == ST_ERR),
    .sq_i        (sq),
    .thresh_i    (thresh_i),
    .epoch_len_i (epoch_len_i),
    .conv_o      (conv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_COLLECT;
      idx_q     <= '0;
      acc_q     <= '0;
      desired_q <= '0;
      mu_q      <= '0;
      y_q       <= '0;
      err_q     <= '0;
    end else if (restart_i) begin
      state_q   <= ST_COLLECT;
      idx_q     <= '0;
      acc_q     <= '0;
    end else begin
      unique case (state_q)
        ST_COLLECT: if (term_fire) begin
          if (idx_q == '0) begin
            desired_q <= desired_i;
            mu_q      <= mu_i;
            acc_q     <= prod_ext;
          end else begin
            acc_q     <= acc_q + prod_ext;
          end
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= ST_ERR;
          end else begin
            idx_q   <= idx_q + IW'(1);
          end
        end
        ST_ERR: begin
          y_q     <= y_sat;
          err_q   <= err_sat;
          state_q <= ST_UPD;
        end
        ST_UPD: begin
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= ST_FIN;
          end else begin
            idx_q   <= idx_q + IW'(1);
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  assign done_o = (state_q == ST_FIN);
  assign y_o    = y_q;
  assign err_o  = err_q;
  assign conv_o = conv;

  AST_NO_ACCEPT_WHEN_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> !ready_o); // R9
  AST_WEIGHTS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_o && state_q == ST_COLLECT && !restart_i) |=> $stable(w_flat)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_ERR) |=> $stable(y_o)); // R3
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST); // R2
endmodule

// File: tb/test_lms_trainer.sv
module test_lms_trainer;
  localparam int NW = 6;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, tv = 1'b0;
  logic [15:0] term = '0, desired = '0, mu = '0, thresh = '0;
  logic [7:0] elen = 8'd8;
  logic [2:0] rd_idx = '0;
  logic ready, done, conv;
  logic [15:0] y, err, rd_w;

  int n_cmp = 0, n_bad = 0;
  longint cyc = 0;
  bit finished = 0;

  longint mw [NW];
  longint m_sum, m_cnt;
  bit m_conv;

  always #10 clk = ~clk;

  lms_trainer i_lms_trainer (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .term_valid_i(tv),
    .term_i(term), .desired_i(desired), .mu_i(mu), .thresh_i(thresh),
    .epoch_len_i(elen), .ready_o(ready), .done_o(done), .y_o(y), .err_o(err),
    .conv_o(conv), .rd_idx_i(rd_idx), .rd_weight_o(rd_w)
  );

  // terms x6, desired, mu
  localparam int VEC [4][8] = '{
    '{ 4096,  2048, -2048,  1024,     0,   512,  3000, 1024},
    '{-4096,  1000,  3000,  -500,  2500,   100, -2000, 2048},
    '{ 8192, -8192,  4096,  4096, -1024,   300, 10000,  512},
    '{  100,   200,   300,   400,   500,   600,  -500, 4096}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint mmul(input longint a, input longint b);
    return sat16((a * b) >>> 12);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NW; k++) mw[k] = 4096;
    m_sum = 0; m_cnt = 0; m_conv = 0;
  endtask

  task automatic model_iter(input int t [NW], input longint d, input longint mu_v,
                            input longint th, input longint len,
                            output longint ey, output longint ee);
    longint acc, g, sq, le;
    acc = 0;
    for (int k = 0; k < NW; k++) acc += mmul(t[k], mw[k]);
    ey = sat16(acc);
    ee = sat16(d - ey);
    g = mmul((mu_v > 4096) ? 4096 : mu_v, ee);
    for (int k = 0; k < NW; k++) mw[k] = sat16(mw[k] + mmul(g, t[k]));
    sq = (ee * ee) >>> 12;
    le = (len == 0) ? 1 : len;
    if (m_cnt + 1 >= le) begin
      if (m_sum + sq < th * le) m_conv = 1;
      m_sum = 0; m_cnt = 0;
    end else begin
      m_sum += sq; m_cnt++;
    end
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    model_reset();
  endtask

  task automatic check_weights(input string tag);
    for (int k = 0; k < NW; k++) begin
      rd_idx = 3'(k);
      #1;
      chk(tag, longint'($signed(rd_w)), mw[k]);
    end
  endtask

  task automatic run_iter(input string tag, input int t [NW], input int d, input int mu_v);
    longint ey, ee;
    int guard;
    guard = 0;
    @(negedge clk);
    while (!ready && guard < 50) begin @(negedge clk); guard++; end
    desired = 16'(d); mu = 16'(mu_v);
    for (int k = 0; k < NW; k++) begin
      tv = 1'b1; term = 16'(t[k]);
      @(negedge clk);
    end
    tv = 1'b0; term = '0;
    guard = 0;
    while (!done && guard < 50) begin @(negedge clk); guard++; end
    model_iter(t, longint'(d), longint'(mu_v), longint'(thresh), longint'(elen), ey, ee);
    chk({tag, " R2 done"}, longint'(done), 1);
    chk({tag, " R3 y"}, longint'($signed(y)), ey);
    chk({tag, " R4 err"}, longint'($signed(err)), ee);
    chk({tag, " R8 conv"}, longint'(conv), longint'(m_conv));
    check_weights({tag, " R5 weight"});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t [NW];
    int dcnt;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 conv after reset", longint'(conv), 0);
    chk("R1 ready after reset", longint'(ready), 1);
    check_weights("R1 weight after reset");

    // table walk: no convergence (threshold 0)
    thresh = 16'd0; elen = 8'd8;
    for (int v = 0; v < 4; v++) begin
      for (int k = 0; k < NW; k++) t[k] = VEC[v][k];
      run_iter($sformatf("vec%0d", v), t, VEC[v][6], VEC[v][7]);
    end

    // R11 out-of-range read
    rd_idx = 3'd7; #1;
    chk("R11 index beyond NW", longint'(rd_w), 0);

    // R6 full-scale saturation
    pulse_restart();
    for (int k = 0; k < NW; k++) t[k] = 32767;
    run_iter("R6 full scale", t, -32768, 4096);
    chk("R6 y clipped", longint'($signed(y)), 32767);
    chk("R6 err clipped", longint'($signed(err)), -32768);
    rd_idx = 3'd0; #1;
    chk("R6 weight", longint'($signed(rd_w)), -28672);

    // R7 oversized rate acts as 1.0
    pulse_restart();
    for (int k = 0; k < NW; k++) t[k] = VEC[0][k];
    run_iter("R7 mu clamp", t, 3000, 16'hFFFF);
    // R7 zero rate leaves weights
    pulse_restart();
    run_iter("R7 mu zero", t, 3000, 0);
    check_weights("R7 unchanged at 1.0");

    // R8 strict threshold, epoch length 1
    pulse_restart();
    elen = 8'd1; thresh = 16'd4096;
    t = '{4096, 0, 0, 0, 0, 0};
    run_iter("R8 at threshold", t, 8192, 0);
    chk("R8 equal not below", longint'(conv), 0);
    thresh = 16'd4097;
    run_iter("R8 one below", t, 8192, 0);
    chk("R8 below sets flag", longint'(conv), 1);

    // R10 restart clears flag; R8 zero epoch length acts as one
    pulse_restart();
    @(negedge clk);
    chk("R10 conv cleared", longint'(conv), 0);
    chk("R10 ready", longint'(ready), 1);
    check_weights("R10 weight 1.0");
    elen = 8'd0;
    run_iter("R8 zero length", t, 8192, 0);
    chk("R8 zero length sets flag", longint'(conv), 1);

    // R8 epoch of two: no flag after first iteration
    pulse_restart();
    elen = 8'd2; thresh = 16'h7FFF;
    for (int k = 0; k < NW; k++) t[k] = VEC[3][k];
    run_iter("R8 epoch first", t, 0, 1024);
    chk("R8 no flag mid-epoch", longint'(conv), 0);
    run_iter("R8 epoch second", t, 0, 1024);
    chk("R8 flag at boundary", longint'(conv), 1);

    // R9 terms ignored while converged
    dcnt = 0;
    @(negedge clk);
    desired = 16'd20000; mu = 16'd4096;
    for (int k = 0; k < NW + 3; k++) begin
      tv = 1'b1; term = 16'd8000;
      @(negedge clk);
      if (done) dcnt++;
      chk("R9 ready low", longint'(ready), 0);
    end
    tv = 1'b0;
    repeat (NW + 3) begin @(negedge clk); if (done) dcnt++; end
    chk("R9 no done pulse", longint'(dcnt), 0);
    chk("R9 flag held", longint'(conv), 1);
    check_weights("R9 weights frozen");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule